// File: doc/BRIEF.md
# Way-Predicting Four-Way Read Cache

This block is a small set-associative read cache that tries to guess, for every set, which of its four ways holds the requested block. The guess is stored as a two-bit field per set. When a request arrives, the guessed way drives the data output multiplexer straight away. If that way's tag matches, the word is returned in the very next cycle. If the guess was wrong, one extra cycle is spent comparing all ways. A true miss issues a refill request toward the next memory level.

A processor side issues read addresses through a valid/ready handshake. Each accepted request receives exactly one response pulse. The pulse carries the data and a two-bit class code telling whether the access was a fast hit, a slow hit or a miss. The lower level answers a refill request with a single data beat. That word is written into a victim way chosen by a per-set round-robin pointer, and it is forwarded to the requester in the same cycle.

Top module: `wp_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid and refill_req are 0, every line is invalid (the first access to any address is a miss), and every set's prediction and victim pointer point at way 0.
- R2: The set is the address modulo SETS (the low address bits) and the tag is the remaining upper bits. Two addresses with equal tags in different sets are distinct blocks.
- R3: When the predicted way of the set holds the block, resp_valid is 1 in the first cycle after acceptance, with resp_kind = 0 (fast) and the stored word.
- R4: When the block is in a way other than the predicted one, resp_valid is 1 in the second cycle after acceptance, with resp_kind = 1 (slow). The set's prediction then names that way, so an immediate repeat of the access is fast.
- R5: On a miss, refill_req rises in the third cycle after acceptance, with refill_addr equal to the request address. Both stay unchanged until refill_valid is seen. The response comes in the cycle refill_valid is 1, with resp_kind = 2 (miss) and resp_data equal to refill_data.
- R6: A refill writes into the way named by the set's round-robin pointer, in the order 0, 1, 2, 3, 0. The pointer advances only on a refill into that set. The refilled way becomes the set's prediction.
- R7: req_ready is 0 from acceptance until the response cycle has ended. A request offered during that time is not taken and produces no response.
- R8: Each accepted request yields exactly one single-cycle resp_valid pulse.
- R9: The prediction and victim pointer of one set are not changed by accesses to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the read |
| resp_valid | output | 1 | Response pulse |
| resp_data | output | DATA_W | Read data |
| resp_kind | output | 2 | 0 fast hit, 1 slow hit, 2 miss |
| refill_req | output | 1 | Request to the next level |
| refill_addr | output | ADDR_W | Address being fetched |
| refill_valid | input | 1 | Refill data present |
| refill_data | input | DATA_W | Refill word |

## Verification
Counting from the clock edge that accepts a request, a fast hit answers in cycle 1 and a slow hit in cycle 2. The refill request of a miss appears in cycle 3. A miss answers in whichever cycle the refill word is presented, which is cycle 5 for the bench's fixed two-cycle refill delay. The bench drives inputs on falling edges, settles briefly, and records the cycle number of the first response. It compares that number with the value its own table predicts for the class. It checks the request address on the refill port, and it checks that the following cycle carries no second pulse.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    KIND_FAST = 2'd0,
    KIND_SLOW = 2'd1,
    KIND_MISS = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE,
    ST_SEARCH,
    ST_FILL
  } state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cur_set,
  input  logic [TAG_W-1:0] cur_tag,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  output logic [WAYS-1:0]  hit_vec
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[cur_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[cur_set][wr_way] <= cur_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[cur_set][w] && (tag_q[cur_set][w] == cur_tag);
  end

  // R2: a block lives in at most one way of its set
  p_single_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  cur_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[cur_set][wr_way] <= wr_data;
  end

  assign rd_data = mem_q[cur_set][rd_way];
endmodule

// File: rtl/wpc_way_ctrl.sv
module wpc_way_ctrl #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cur_set,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             adv_en,
  output logic [WAY_W-1:0] pred_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAY_W-1:0] pred_q [SETS];
  logic [WAY_W-1:0] rr_q   [SETS];

  function automatic logic [WAY_W-1:0] next_victim(input logic [WAY_W-1:0] w);
    return (int'(w) == WAYS - 1) ? '0 : w + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        pred_q[s] <= '0;
        rr_q[s]   <= '0;
      end
    end else begin
      if (upd_en) pred_q[cur_set] <= upd_way;
      if (adv_en) rr_q[cur_set]   <= next_victim(rr_q[cur_set]);
    end
  end

  assign pred_way   = pred_q[cur_set];
  assign victim_way = rr_q[cur_set];

  // R6: pointer steps by one way per refill (set held stable after a fill)
  p_rr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> victim_way == next_victim($past(victim_way)));
  // R4: the prediction names the way written last
  p_pred_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> pred_way == $past(upd_way));
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_kind,
  output logic              refill_req,
  output logic [ADDR_W-1:0] refill_addr,
  input  logic              refill_valid,
  input  logic [DATA_W-1:0] refill_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [WAY_W-1:0] first_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  cur_set;
  logic [WAYS-1:0]   hit_vec;
  logic [WAY_W-1:0]  pred_way, victim_way, found_way, rd_way;
  logic [DATA_W-1:0] rd_data;

  // named internal events
  logic accept, probe_fast, probe_miss, search_hit, search_miss, fill_done;

  assign cur_set     = set_of(addr_q);
  assign found_way   = first_way(hit_vec);
  assign accept      = req_valid && req_ready;
  assign probe_fast  = (state_q == ST_PROBE) && hit_vec[pred_way];
  assign probe_miss  = (state_q == ST_PROBE) && !hit_vec[pred_way];
  assign search_hit  = (state_q == ST_SEARCH) && (|hit_vec);
  assign search_miss = (state_q == ST_SEARCH) && !(|hit_vec);
  assign fill_done   = (state_q == ST_FILL) && refill_valid;
  assign rd_way      = (state_q == ST_SEARCH) ? found_way : pred_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        state_q <= ST_PROBE;
      end
      if (probe_fast || search_hit || fill_done) state_q <= ST_IDLE;
      if (probe_miss)  state_q <= ST_SEARCH;
      if (search_miss) state_q <= ST_FILL;
    end
  end

  wpc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .cur_set(cur_set), .cur_tag(tag_of(addr_q)),
    .wr_en(fill_done), .wr_way(victim_way), .hit_vec(hit_vec));

  wpc_data_store #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .cur_set(cur_set), .rd_way(rd_way), .rd_data(rd_data),
    .wr_en(fill_done), .wr_way(victim_way), .wr_data(refill_data));

  wpc_way_ctrl #(.SETS(SETS), .WAYS(WAYS)) u_ways (
    .clk(clk), .rst_n(rst_n), .cur_set(cur_set),
    .upd_en(search_hit || fill_done),
    .upd_way(fill_done ? victim_way : found_way),
    .adv_en(fill_done), .pred_way(pred_way), .victim_way(victim_way));

  assign req_ready   = (state_q == ST_IDLE);
  assign resp_valid  = probe_fast || search_hit || fill_done;
  assign resp_data   = fill_done ? refill_data : rd_data;
  assign resp_kind   = fill_done ? KIND_MISS : (search_hit ? KIND_SLOW : KIND_FAST);
  assign refill_req  = (state_q == ST_FILL);
  assign refill_addr = addr_q;

  // R3: a fast answer follows acceptance by one cycle
  p_fast_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == KIND_FAST) |-> $past(req_valid && req_ready));
  // R4: a slow answer follows acceptance by two cycles
  p_slow_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == KIND_SLOW) |-> $past(req_valid && req_ready, 2));
  // R5: refill request and address held until data comes
  p_fill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));
  // R5: a miss answer only while refilling
  p_miss_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == KIND_MISS) |-> (refill_req && refill_valid));
  // R7: no new request is taken in a response cycle
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  // R8: responses are single-cycle pulses
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
endmodule

// File: tb/sim_wp_cache.sv
`timescale 1ns/1ps
module sim_wp_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        resp_valid;
  logic [31:0] resp_data;
  logic [1:0]  resp_kind;
  logic        refill_req;
  logic [15:0] refill_addr;
  logic        refill_valid = 1'b0;
  logic [31:0] refill_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wp_cache u0 (.*);

  // R3, R4, R5: class codes and answer cycles counted from acceptance
  localparam logic [1:0] FAST = 2'd0, SLOW = 2'd1, MISS = 2'd2;

  // {address, expected class}; set 1 unless noted
  localparam logic [17:0] VEC [20] = '{
    {16'h0009, MISS}, {16'h0009, FAST}, {16'h0011, MISS}, {16'h0011, FAST},
    {16'h0009, SLOW}, {16'h0009, FAST}, {16'h0019, MISS}, {16'h0021, MISS},
    {16'h0029, MISS}, {16'h0029, FAST}, {16'h0009, MISS}, {16'h0011, MISS},
    {16'h0021, SLOW}, {16'h000A, MISS}, {16'h000A, FAST}, {16'h0021, FAST},
    {16'h0019, MISS}, {16'h0029, SLOW}, {16'h0021, MISS}, {16'h0029, MISS}
  };

  function automatic logic [31:0] word_for(input logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction

  function automatic int due_cycle(input logic [1:0] k);
    return (k == FAST) ? 1 : (k == SLOW) ? 2 : 5;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [1:0] ek, input string rq,
                        input bit intrude, input logic [15:0] ia);
    int lat = 0, rq_at = 0;
    logic [1:0] k = '0;
    logic [31:0] d = '0;
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    #1 chk(req_ready == 1'b1, "R7", "ready before accept", req_ready, 1);
    @(negedge clk); req_valid = 1'b0;
    for (int n = 1; n <= 20 && lat == 0; n++) begin
      if (n > 1) @(negedge clk);
      if (intrude && n <= 3) begin req_valid = 1'b1; req_addr = ia; end
      else req_valid = 1'b0;
      if (refill_req && rq_at == 0) begin
        rq_at = n;
        chk(refill_addr == a, "R5", "refill address", refill_addr, a);
      end
      if (rq_at != 0 && n == rq_at + 2) begin
        refill_valid = 1'b1; refill_data = word_for(a);
      end
      #1;
      if (intrude && n <= 3) chk(req_ready == 1'b0, "R7", "ready while busy", req_ready, 0);
      if (resp_valid) begin lat = n; k = resp_kind; d = resp_data; end
    end
    req_valid = 1'b0;
    chk(lat == due_cycle(ek), rq, "answer cycle", lat, due_cycle(ek));
    chk(k == ek, rq, "class code", k, ek);
    chk(d == word_for(a), rq, "data", d, word_for(a));
    chk(rq_at == ((ek == MISS) ? 3 : 0), "R5", "refill request cycle", rq_at,
        (ek == MISS) ? 3 : 0);
    @(negedge clk); refill_valid = 1'b0;
    #1 chk(resp_valid == 1'b0, "R8", "single pulse", resp_valid, 0);
    chk(req_ready == 1'b1, "R7", "ready after answer", req_ready, 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1;
    $finish;
  endtask

  initial begin
    do_reset();
    #1;
    // R1: idle outputs after reset
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
    chk(refill_req == 1'b0, "R1", "no refill after reset", refill_req, 0);

    // table walk: R2 (0x000A is set 2), R3, R4, R6 (evictions), R9 (set 2 vs set 1)
    for (int i = 0; i < 20; i++) begin
      string tagn;
      tagn = (VEC[i][1:0] == FAST) ? "R3" : (VEC[i][1:0] == SLOW) ? "R4" : "R6";
      if (i == 13) tagn = "R2";
      if (i == 15) tagn = "R9";
      access(VEC[i][17:2], VEC[i][1:0], tagn, 1'b0, 16'h0);
    end

    // R7: a request offered during a miss is not taken
    access(16'h0031, MISS, "R7", 1'b1, 16'h0019);
    access(16'h0019, SLOW, "R4", 1'b0, 16'h0);
    access(16'h0019, FAST, "R4", 1'b0, 16'h0);

    // R1: reset drops valid lines
    do_reset();
    access(16'h0029, MISS, "R1", 1'b0, 16'h0);
    access(16'h0029, FAST, "R1", 1'b0, 16'h0);
    summary();
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule